// File: doc/BRIEF.md
# Status-Polled Flash Bank Erase and Program Sequencer

This block rewrites one bank of a byte-wide flash device that is driven by a command and status-register protocol. A host pulses `start` with a bank index. The block then erases the bank, polls for completion, and reads the whole bank back to confirm it is blank. It then programs the bank one byte at a time from a synchronous source buffer, polls after every byte, and reads the bank back a second time to compare it with the buffer.

Every wait for the device is bounded by a count of status reads. Every device operation is followed by a clear-status and a return-to-array command. The block reports the result with a one-cycle `done` pulse and three fields: a fail flag, a failure kind and the stage in which the failure happened.

Top module: `flash_bank_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy`, `done`, `fail`, `dev_we` and `dev_re` are all low.
- R2: A `start` seen while idle captures `bank`, and `busy` goes high in the next cycle. A `start` seen while busy is ignored: the bank being rewritten does not change and only one `done` results.
- R3: Erase begins with command 0x20 and then command 0xD0, both written to the bank base address. The base address is the bank index times 2^BANK_AW, and no other bank is touched.
- R4: A status poll writes 0x70 to the base address and then reads one status byte. Polling repeats until bit 7 of the status byte is set. If any of status bits 5:3 is set when bit 7 is seen, the run ends with fail kind 1 (status).
- R5: If POLL_LIMIT status reads in a row show bit 7 clear, the run ends with fail kind 2 (timeout). A timeout during programming stops the byte loop, so no further byte is started.
- R6: After erase polling and after the programming loop ends, including when it ends by a status fault or a timeout, the block writes 0x50 and then 0xFF to the base address.
- R7: After a clean erase, every byte of the bank is read back and must equal 0xFF. Any other value ends the run with fail kind 3 at stage 0 (erase), and no byte is programmed.
- R8: Bytes are programmed in ascending order. For each byte, 0x40 is written to the byte's address, the data write to the same address follows exactly SETUP_WAIT+1 cycles later, and each byte is polled before the next byte starts.
- R9: After programming, every byte is read back and compared with the source buffer. A difference ends the run with fail kind 3 at stage 1 (program).
- R10: Verify reads are issued in consecutive cycles. At most one read is issued past the first mismatching byte.
- R11: `done` is a single-cycle pulse. `fail`, `fail_kind` (0 none, 1 status, 2 timeout, 3 verify) and `fail_stage` (0 erase, 1 program) are valid while `done` is high and hold until the next accepted `start`.
- R12: `src_addr` carries the byte index within the bank. The source buffer returns that byte one cycle later on `src_data`, and that byte is the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a rewrite; used only while idle |
| bank | input | BANK_W | Bank index, captured at start |
| busy | output | 1 | A rewrite is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Run ended with an error |
| fail_kind | output | 2 | 0 none, 1 status fault, 2 timeout, 3 verify |
| fail_stage | output | 1 | 0 erase, 1 program |
| src_addr | output | BANK_AW | Source buffer byte index |
| src_data | input | 8 | Source byte, one cycle after `src_addr` |
| dev_addr | output | BANK_W+BANK_AW | Device byte address |
| dev_wdata | output | 8 | Device write data or command |
| dev_rdata | input | 8 | Device read data, one cycle after `dev_re` |
| dev_we | output | 1 | Device write strobe |
| dev_re | output | 1 | Device read strobe |

## Verification
An error in the sequencer state shows up on the device bus within a few cycles. The likely symptoms are a command written to the wrong address, a data write that comes too soon after its setup command, or a 0xFF reset that is not preceded by 0x50. A device model in the bench flags each of these at the write where it happens. A wrong count in the poll, byte or verify counters shows up later, as a total of status reads, programmed bytes or array reads that does not match the figure worked out for that run. These totals are checked against fault injections that force timeouts, status faults and stuck bytes at chosen positions.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ER_SETUP, S_ER_CONFIRM, S_PG_SETUP, S_PG_WAIT, S_PG_DATA,
    S_ST_CMD, S_ST_READ, S_ST_CHECK, S_CLR, S_RST, S_VF_RUN, S_VF_LAST,
    S_FINISH
  } seq_state_e;

  typedef enum logic [1:0] {
    FK_NONE    = 2'd0,
    FK_STATUS  = 2'd1,
    FK_TIMEOUT = 2'd2,
    FK_VERIFY  = 2'd3
  } fail_kind_e;

  localparam logic [7:0] CMD_ERASE_ARM  = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
  localparam logic [7:0] CMD_PROG_ARM   = 8'h40;
  localparam logic [7:0] CMD_STATUS     = 8'h70;
  localparam logic [7:0] CMD_CLEAR      = 8'h50;
  localparam logic [7:0] CMD_ARRAY      = 8'hFF;
  localparam logic [7:0] ST_READY_MASK  = 8'h80;
  localparam logic [7:0] ST_FAULT_MASK  = 8'h38;
  localparam logic [7:0] BLANK_BYTE     = 8'hFF;

endpackage

// File: rtl/flash_seq_delay.sv
module flash_seq_delay #(
  parameter int SETUP_WAIT = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = (SETUP_WAIT < 2) ? 1 : $clog2(SETUP_WAIT + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(SETUP_WAIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= LOAD_V;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R8
  delay_armed_chk: assert property (@(posedge clk) disable iff (rst)
    (load && SETUP_WAIT > 1) |=> !expired);

endmodule

// File: rtl/flash_seq_pollcnt.sv
module flash_seq_pollcnt #(
  parameter int POLL_LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] LAST_V = CW'(POLL_LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (bump)    cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == LAST_V);

  // R5
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(POLL_LIMIT));

  // R5
  no_bump_at_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (bump && !clear) |-> !last);

endmodule

// File: rtl/flash_bank_sequencer.sv
module flash_bank_sequencer
  import flash_seq_pkg::*;
#(
  parameter int BANK_AW    = 13,
  parameter int BANK_W     = 1,
  parameter int SETUP_WAIT = 50,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [BANK_W-1:0]         bank,
  output logic                      busy,
  output logic                      done,
  output logic                      fail,
  output logic [1:0]                fail_kind,
  output logic                      fail_stage,
  output logic [BANK_AW-1:0]        src_addr,
  input  logic [7:0]                src_data,
  output logic [BANK_W+BANK_AW-1:0] dev_addr,
  output logic [7:0]                dev_wdata,
  input  logic [7:0]                dev_rdata,
  output logic                      dev_we,
  output logic                      dev_re
);
  localparam int DEV_AW = BANK_W + BANK_AW;
  localparam logic [BANK_AW-1:0] LAST_IDX = '1;

  seq_state_e          state_q;
  fail_kind_e          kind_q;
  logic [BANK_W-1:0]   bank_q;
  logic [BANK_AW-1:0]  idx_q;
  logic                pgm_q, vpend_q, stage_q, busy_q, done_q, fail_q;

  logic wait_load, wait_done, poll_clear, poll_bump, poll_last;
  logic st_ready, st_fault, vf_mismatch;
  logic [7:0] vf_expect;
  logic [DEV_AW-1:0] base_addr, byte_addr;

  flash_seq_delay #(.SETUP_WAIT(SETUP_WAIT)) u_delay (
    .clk(clk), .rst(rst), .load(wait_load), .expired(wait_done));

  flash_seq_pollcnt #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst(rst), .clear(poll_clear), .bump(poll_bump), .last(poll_last));

  assign base_addr   = {bank_q, {BANK_AW{1'b0}}};
  assign byte_addr   = {bank_q, idx_q};
  assign st_ready    = |(dev_rdata & ST_READY_MASK);
  assign st_fault    = |(dev_rdata & ST_FAULT_MASK);
  assign vf_expect   = pgm_q ? src_data : BLANK_BYTE;
  assign vf_mismatch = (dev_rdata != vf_expect);

  // Bus and helper decode from registered state only.
  always_comb begin
    dev_we     = 1'b0;
    dev_re     = 1'b0;
    dev_addr   = base_addr;
    dev_wdata  = 8'h00;
    wait_load  = 1'b0;
    poll_clear = 1'b0;
    poll_bump  = 1'b0;
    unique case (state_q)
      S_ER_SETUP:   begin dev_we = 1'b1; dev_wdata = CMD_ERASE_ARM; end
      S_ER_CONFIRM: begin dev_we = 1'b1; dev_wdata = CMD_ERASE_GO; poll_clear = 1'b1; end
      S_PG_SETUP:   begin dev_we = 1'b1; dev_addr = byte_addr; dev_wdata = CMD_PROG_ARM;
                          wait_load = 1'b1; end
      S_PG_DATA:    begin dev_we = 1'b1; dev_addr = byte_addr; dev_wdata = src_data;
                          poll_clear = 1'b1; end
      S_ST_CMD:     begin dev_we = 1'b1; dev_wdata = CMD_STATUS; end
      S_ST_READ:    dev_re = 1'b1;
      S_ST_CHECK:   poll_bump = !st_ready && !poll_last;
      S_CLR:        begin dev_we = 1'b1; dev_wdata = CMD_CLEAR; end
      S_RST:        begin dev_we = 1'b1; dev_wdata = CMD_ARRAY; end
      S_VF_RUN:     begin dev_re = 1'b1; dev_addr = byte_addr; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      kind_q  <= FK_NONE;
      bank_q  <= '0;
      idx_q   <= '0;
      pgm_q   <= 1'b0;
      vpend_q <= 1'b0;
      stage_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start) begin
          bank_q  <= bank;
          idx_q   <= '0;
          pgm_q   <= 1'b0;
          kind_q  <= FK_NONE;
          stage_q <= 1'b0;
          fail_q  <= 1'b0;
          busy_q  <= 1'b1;
          state_q <= S_ER_SETUP;
        end
        S_ER_SETUP:   state_q <= S_ER_CONFIRM;
        S_ER_CONFIRM: state_q <= S_ST_CMD;
        S_PG_SETUP:   state_q <= S_PG_WAIT;
        S_PG_WAIT:    if (wait_done) state_q <= S_PG_DATA;
        S_PG_DATA:    state_q <= S_ST_CMD;
        S_ST_CMD:     state_q <= S_ST_READ;
        S_ST_READ:    state_q <= S_ST_CHECK;
        S_ST_CHECK: begin
          if (st_ready) begin
            if (st_fault) begin
              kind_q  <= FK_STATUS;
              stage_q <= pgm_q;
              state_q <= S_CLR;
            end else if (pgm_q && idx_q != LAST_IDX) begin
              idx_q   <= idx_q + 1'b1;
              state_q <= S_PG_SETUP;
            end else begin
              state_q <= S_CLR;
            end
          end else if (poll_last) begin
            kind_q  <= FK_TIMEOUT;
            stage_q <= pgm_q;
            state_q <= S_CLR;
          end else begin
            state_q <= S_ST_CMD;
          end
        end
        S_CLR: state_q <= S_RST;
        S_RST: begin
          idx_q   <= '0;
          vpend_q <= 1'b0;
          state_q <= (kind_q != FK_NONE) ? S_FINISH : S_VF_RUN;
        end
        S_VF_RUN: begin
          if (vpend_q && vf_mismatch) begin
            kind_q  <= FK_VERIFY;
            stage_q <= pgm_q;
            state_q <= S_FINISH;
          end else if (idx_q == LAST_IDX) begin
            state_q <= S_VF_LAST;
          end else begin
            idx_q   <= idx_q + 1'b1;
            vpend_q <= 1'b1;
          end
        end
        S_VF_LAST: begin
          if (vf_mismatch) begin
            kind_q  <= FK_VERIFY;
            stage_q <= pgm_q;
            state_q <= S_FINISH;
          end else if (!pgm_q) begin
            pgm_q   <= 1'b1;
            idx_q   <= '0;
            state_q <= S_PG_SETUP;
          end else begin
            state_q <= S_FINISH;
          end
        end
        S_FINISH: begin
          done_q  <= 1'b1;
          fail_q  <= (kind_q != FK_NONE);
          busy_q  <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign fail       = fail_q;
  assign fail_kind  = kind_q;
  assign fail_stage = stage_q;
  assign src_addr   = idx_q;

  // R1
  bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dev_we && dev_re));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  fail_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !fail) |-> (fail_kind == 2'd0));

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(bank_q));

  // R8
  setup_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_PG_DATA) |-> ($past(state_q) == S_PG_WAIT));

endmodule

// File: tb/flash_bank_sequencer_tb.sv
`timescale 1ns/1ps
module flash_bank_sequencer_tb;
  localparam int BANK_AW = 4;
  localparam int BANK_W  = 1;
  localparam int SW      = 3;
  localparam int PL      = 8;
  localparam int NB      = 1 << BANK_AW;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [BANK_W-1:0] bank = '0;
  logic busy, done, fail, fail_stage, dev_we, dev_re;
  logic [1:0] fail_kind;
  logic [BANK_AW-1:0] src_addr;
  logic [7:0] src_data = 8'h00, dev_wdata, dev_rdata = 8'h00;
  logic [BANK_W+BANK_AW-1:0] dev_addr;

  always #2 clk = ~clk;

  flash_bank_sequencer #(.BANK_AW(BANK_AW), .BANK_W(BANK_W), .SETUP_WAIT(SW),
                         .POLL_LIMIT(PL)) u_dut (
    .clk(clk), .rst(rst), .start(start), .bank(bank), .busy(busy), .done(done),
    .fail(fail), .fail_kind(fail_kind), .fail_stage(fail_stage),
    .src_addr(src_addr), .src_data(src_data), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_we(dev_we), .dev_re(dev_re));

  // Device and buffer model
  logic [7:0] mem [0:2*NB-1];
  logic [7:0] sbuf [0:NB-1];
  int mode = 0, busy_left = 0, lat = 0, run_base = 0;
  logic [7:0] fault_bits = 8'h00, prev_cmd = 8'h00;
  int hang_erase = 0, fault_erase = 0, hang_prog = -1, fault_prog = -1;
  int stuck_erase = -1, stuck_prog = -1;
  int cyc = 0, n_setup = 0, n_stcmd = 0, n_strd = 0, n_clear = 0, n_reset = 0;
  int n_arr = 0, arr_gaps = 0, prev_arr = 0, n_done = 0, seq_bad = 0;
  int exp_idx = 0, c40 = 0;
  int n_tests = 0, n_fail = 0;

  always @(posedge clk) begin
    cyc++;
    src_data <= sbuf[src_addr];
    if (done) n_done++;
    if (dev_we) begin
      if (mode == 3) begin
        if (int'(dev_addr) != run_base + exp_idx || cyc - c40 != SW + 1 ||
            dev_wdata != sbuf[exp_idx]) seq_bad++;
        mem[dev_addr] = dev_wdata & ((exp_idx == stuck_prog) ? 8'hFE : 8'hFF);
        busy_left = (exp_idx == hang_prog) ? 1000 : lat;
        fault_bits = (exp_idx == fault_prog) ? 8'h10 : 8'h00;
        exp_idx++;
        mode = 1;
      end else if (mode == 2) begin
        if (dev_wdata != 8'hD0 || int'(dev_addr) != run_base) seq_bad++;
        for (int j = 0; j < NB; j++)
          mem[run_base + j] = (j == stuck_erase) ? 8'h00 : 8'hFF;
        busy_left = hang_erase ? 1000 : lat;
        fault_bits = fault_erase ? 8'h08 : 8'h00;
        mode = 1;
      end else begin
        case (dev_wdata)
          8'h20: begin mode = 2; if (int'(dev_addr) != run_base) seq_bad++; end
          8'h40: begin mode = 3; n_setup++; c40 = cyc;
                   if (int'(dev_addr) != run_base + exp_idx) seq_bad++; end
          8'h70: begin mode = 1; n_stcmd++; if (int'(dev_addr) != run_base) seq_bad++; end
          8'h50: begin n_clear++; fault_bits = 8'h00;
                   if (int'(dev_addr) != run_base) seq_bad++; end
          8'hFF: begin n_reset++; mode = 0;
                   if (int'(dev_addr) != run_base || prev_cmd != 8'h50) seq_bad++; end
          default: seq_bad++;
        endcase
      end
      prev_cmd = dev_wdata;
    end
    if (dev_re) begin
      if (mode == 1) begin
        n_strd++;
        if (busy_left > 0) begin dev_rdata <= 8'h00; busy_left--; end
        else dev_rdata <= 8'h80 | fault_bits;
      end else begin
        if (n_arr > 0 && cyc != prev_arr + 1) arr_gaps++;
        prev_arr = cyc;
        n_arr++;
        dev_rdata <= mem[dev_addr];
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp_v);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic clear_inj();
    hang_erase = 0; fault_erase = 0; hang_prog = -1; fault_prog = -1;
    stuck_erase = -1; stuck_prog = -1;
  endtask

  int r_fail, r_kind, r_stage;

  task automatic run(input int b, input int l, input int intrude);
    int w;
    run_base = b * NB; lat = l;
    n_setup = 0; n_stcmd = 0; n_strd = 0; n_clear = 0; n_reset = 0;
    n_arr = 0; arr_gaps = 0; n_done = 0; seq_bad = 0; exp_idx = 0;
    @(negedge clk); start = 1'b1; bank = BANK_W'(b);
    @(negedge clk); start = 1'b0; bank = BANK_W'(b ^ 1);
    chk("R2 busy after start", int'(busy), 1);
    w = 0;
    while (done !== 1'b1 && w < 6000) begin
      @(negedge clk); w++;
      if (intrude != 0 && w == 20) start = 1'b1;
      if (intrude != 0 && w == 21) start = 1'b0;
    end
    r_fail = int'(fail); r_kind = int'(fail_kind); r_stage = int'(fail_stage);
    chk("R2 busy low at done", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R11 single done", n_done, 1);
    chk("R11 fields held", int'(fail_kind), r_kind);
  endtask

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'((i * 37 + p * 91 + 3) ^ (p << 5));
  endfunction

  task automatic fill(input int b, input int p);
    for (int i = 0; i < NB; i++) begin
      sbuf[i] = pat(p, i);
      mem[b * NB + i] = 8'h3C ^ 8'(i);
      mem[(b ^ 1) * NB + i] = 8'h5A;
    end
  endtask

  task automatic chk_banks(input int b, input string req);
    int bad = 0, other = 0;
    for (int i = 0; i < NB; i++) begin
      if (mem[b * NB + i] != sbuf[i]) bad++;
      if (mem[(b ^ 1) * NB + i] != 8'h5A) other++;
    end
    chk({req, " bank content"}, bad, 0);
    chk("R3 other bank untouched", other, 0);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    for (int i = 0; i < 2 * NB; i++) mem[i] = 8'h00;
    for (int i = 0; i < NB; i++) sbuf[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 bus idle in reset", int'(dev_we | dev_re), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 done/fail after reset", int'(done | fail), 0);
    chk("R1 bus idle after reset", int'(dev_we | dev_re), 0);

    // Sweep: both banks, three poll latencies, three patterns
    clear_inj();
    for (int b = 0; b < 2; b++)
      for (int l = 0; l < 3; l++)
        for (int p = 0; p < 3; p++) begin
          fill(b, p);
          run(b, l, 0);
          chk("R11 fail clear", r_fail, 0);
          chk("R11 kind none", r_kind, 0);
          chk_banks(b, "R9 R12");
          chk("R8 bytes programmed", n_setup, NB);
          chk("R4 status commands", n_stcmd, (NB + 1) * (l + 1));
          chk("R4 status reads", n_strd, (NB + 1) * (l + 1));
          chk("R6 clear count", n_clear, 2);
          chk("R6 reset count", n_reset, 2);
          chk("R7 verify reads", n_arr, 2 * NB);
          chk("R10 verify streams", arr_gaps, 1);
          chk("R3 R8 bus sequence", seq_bad, 0);
        end

    // Start while busy is ignored
    fill(0, 4);
    run(0, 1, 1);
    chk("R2 intrusion fail", r_fail, 0);
    chk_banks(0, "R2");
    chk("R2 sequence", seq_bad, 0);

    // Erase timeout
    fill(1, 5); clear_inj(); hang_erase = 1;
    run(1, 0, 0);
    chk("R5 erase timeout kind", r_kind, 2);
    chk("R5 erase timeout stage", r_stage, 0);
    chk("R5 status reads at limit", n_strd, PL);
    chk("R5 no programming", n_setup, 0);
    chk("R6 clear after timeout", n_clear, 1);
    chk("R6 reset after timeout", n_reset, 1);
    chk("R5 no verify", n_arr, 0);

    // Program timeout at byte 3
    fill(0, 6); clear_inj(); hang_prog = 3;
    run(0, 1, 0);
    chk("R5 program timeout kind", r_kind, 2);
    chk("R5 program timeout stage", r_stage, 1);
    chk("R5 loop stops", n_setup, 4);
    chk("R5 status reads", n_strd, 2 * 4 + PL);
    chk("R6 clear count", n_clear, 2);

    // Status fault at byte 2
    fill(1, 7); clear_inj(); fault_prog = 2;
    run(1, 0, 0);
    chk("R4 status fault kind", r_kind, 1);
    chk("R4 status fault stage", r_stage, 1);
    chk("R4 loop stops", n_setup, 3);
    chk("R6 reset after fault", n_reset, 2);
    chk("R4 only erase verify", n_arr, NB);

    // Status fault during erase
    fill(0, 8); clear_inj(); fault_erase = 1;
    run(0, 2, 0);
    chk("R4 erase fault kind", r_kind, 1);
    chk("R4 erase fault stage", r_stage, 0);
    chk("R4 erase fault no program", n_setup, 0);

    // Erase verify mismatch at byte 5 and at last byte
    fill(0, 9); clear_inj(); stuck_erase = 5;
    run(0, 0, 0);
    chk("R7 blank check kind", r_kind, 3);
    chk("R7 blank check stage", r_stage, 0);
    chk("R7 no programming", n_setup, 0);
    chk("R10 early stop reads", n_arr, 7);
    chk("R11 fail flag", r_fail, 1);

    fill(1, 10); clear_inj(); stuck_erase = NB - 1;
    run(1, 0, 0);
    chk("R7 last byte kind", r_kind, 3);
    chk("R10 last byte reads", n_arr, NB);

    // Program verify mismatch at byte 9
    fill(0, 11); clear_inj(); sbuf[9] = 8'h81; stuck_prog = 9;
    run(0, 0, 0);
    chk("R9 compare kind", r_kind, 3);
    chk("R9 compare stage", r_stage, 1);
    chk("R10 program verify reads", n_arr, NB + 11);
    chk("R8 all bytes written", n_setup, NB);

    // Clean run after failures clears result fields
    fill(1, 12); clear_inj();
    run(1, 2, 0);
    chk("R11 result cleared", r_kind, 0);
    chk_banks(1, "R9");

    report();
  end
endmodule